// File: doc/BRIEF.md
# Dual-Source Handshake FIFO

A synchronous first-in first-out buffer holding up to `DEPTH` words of `DW` bits. A push stores a word taken from one of two input buses. The bus is chosen on every push by a select line, so two producers can share one buffer without an external multiplexer. Each direction uses a request/acknowledge pair, and the acknowledge is the only report of occupancy. A refused pop means the buffer was empty. A refused push means it was full and no pop freed a slot in the same cycle.

The control is a three-state machine over the occupancy. **ST_EMPTY** holds no words. **ST_PART** holds between 1 and `DEPTH-1` words. **ST_FULL** holds `DEPTH` words. The machine has four named transitions:
- **T_FIRST**: ST_EMPTY to ST_PART, on an accepted push.
- **T_DRAIN**: ST_PART to ST_EMPTY, on a lone pop of the last word.
- **T_TOPUP**: ST_PART to ST_FULL, on a lone push into the last free slot.
- **T_RELIEVE**: ST_FULL to ST_PART, on a lone pop.

Every other case keeps the current state. In ST_FULL, a pop plus a push stays in ST_FULL. The pointers wrap modulo `DEPTH`. A counter with one more bit than the pointers keeps the occupancy.

Top module: `dualsrc_fifo`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `push_ack`, `pop_ack` and `rdata` are all 0, and the buffer is empty.
- R2: A push with `src_sel` = 0 stores the word on `wdata_a`.
- R3: A push with `src_sel` = 1 stores the word on `wdata_b`.
- R4: `pop_ack` is 1 only in the cycle after an accepted pop. A pop request while empty gives `pop_ack` = 0.
- R5: `push_ack` is 1 only in the cycle after an accepted push. A lone push request while `DEPTH` words are held gives `push_ack` = 0.
- R6: Both acknowledges are registered and appear one cycle after the request edge. In the cycle where `pop_ack` is 1, `rdata` holds the popped word.
- R7: With 1 to `DEPTH-1` words held, a pop and a push in the same cycle both succeed.
- R8: With `DEPTH` words held, a pop and a push in the same cycle both succeed, and the buffer stays full.
- R9: With the buffer empty, a pop and a push in the same cycle accept only the push.
- R10: Words leave in push order, whichever bus supplied each one, including after the pointers wrap.
- R11: A refused request leaves the stored words and `rdata` unchanged.
- R12: Asserting reset in the middle of operation empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to store a word |
| pop_req | input | 1 | Request to remove the oldest word |
| src_sel | input | 1 | Selects the push source: 0 is `wdata_a`, 1 is `wdata_b` |
| wdata_a | input | DW | First push data bus |
| wdata_b | input | DW | Second push data bus |
| push_ack | output | 1 | The previous cycle's push was stored |
| pop_ack | output | 1 | The previous cycle's pop removed a word |
| rdata | output | DW | The most recently popped word |

## Verification
Pushes alternate the select line, and the two buses always carry different words. A word that arrives from the wrong bus, or in the wrong order, therefore shows up as a data mismatch. Requests are tried in every state: lone pops and lone pushes, and combined pop-and-push in the empty, partial and full states. These separate the acceptance rule of each state from the others. A run longer than the depth makes the pointers wrap. A reset in the middle of a run shows that the stored contents are discarded.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    // Occupancy class of the buffer
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_t;

    // Names of the state transitions, exposed for observation
    typedef enum logic [2:0] {
        T_HOLD    = 3'd0,
        T_FIRST   = 3'd1,
        T_DRAIN   = 3'd2,
        T_TOPUP   = 3'd3,
        T_RELIEVE = 3'd4
    } occ_move_t;

endpackage

// File: rtl/dsf_wsel.sv
module dsf_wsel #(
    parameter int DW = 32
) (
    input  logic          sel,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] word
);

    // Only one source ever reaches the storage on a given push
    always_comb begin
        unique case (sel)
            1'b0:    word = src_a;
            1'b1:    word = src_b;
            default: word = src_a;
        endcase
    end

endmodule

// File: rtl/dsf_store.sv
module dsf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_word,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_ptr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] slot_we;
    logic [DW-1:0]    rd_word_q;

    // Per-slot write enable decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_we[g] = wr_en && (wr_ptr == AW'(g));
    end

    // Storage has no reset: contents are meaningless until written
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                mem[i] <= wr_word;
            end
        end
    end

    // Output register: changes only on an accepted pop.
    // The read samples the old contents, so a pop and a push to the
    // same slot in one cycle return the older word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_word_q <= '0;
        end else if (rd_en) begin
            rd_word_q <= mem[rd_ptr];
        end
    end

    assign rd_word = rd_word_q;

endmodule

// File: rtl/dsf_ctrl.sv
module dsf_ctrl
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] occ,
    output occ_state_t    state,
    output occ_move_t     move,
    output logic          push_ack,
    output logic          pop_ack
);

    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] OCC_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] OCC_ONE  = CW'(1);
    localparam logic [CW-1:0] OCC_TOP  = CW'(DEPTH - 1);

    occ_state_t    state_q, state_d;
    occ_move_t     move_d;
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] occ_q, occ_d;
    logic          push_ok, pop_ok;
    logic          push_ack_q, pop_ack_q;

    // Output process: acceptance decided by the current state
    always_comb begin
        pop_ok  = 1'b0;
        push_ok = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                pop_ok  = 1'b0;
                push_ok = push_req;
            end
            ST_PART: begin
                pop_ok  = pop_req;
                push_ok = push_req;
            end
            ST_FULL: begin
                pop_ok  = pop_req;
                push_ok = push_req && pop_req;
            end
            default: begin
                pop_ok  = 1'b0;
                push_ok = 1'b0;
            end
        endcase
    end

    // Next-state and transition naming
    always_comb begin
        state_d = state_q;
        move_d  = T_HOLD;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_ok) begin
                    state_d = (DEPTH == 1) ? ST_FULL : ST_PART;
                    move_d  = T_FIRST;
                end
            end
            ST_PART: begin
                if (push_ok && !pop_ok && (occ_q == OCC_TOP)) begin
                    state_d = ST_FULL;
                    move_d  = T_TOPUP;
                end else if (pop_ok && !push_ok && (occ_q == OCC_ONE)) begin
                    state_d = ST_EMPTY;
                    move_d  = T_DRAIN;
                end
            end
            ST_FULL: begin
                if (pop_ok && !push_ok) begin
                    state_d = (DEPTH == 1) ? ST_EMPTY : ST_PART;
                    move_d  = T_RELIEVE;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                move_d  = T_HOLD;
            end
        endcase
    end

    // Occupancy bookkeeping
    always_comb begin
        occ_d = occ_q;
        unique case ({push_ok, pop_ok})
            2'b10:   occ_d = occ_q + OCC_ONE;
            2'b01:   occ_d = occ_q - OCC_ONE;
            default: occ_d = occ_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Pointers, counter and acknowledges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            occ_q      <= '0;
            push_ack_q <= 1'b0;
            pop_ack_q  <= 1'b0;
        end else begin
            occ_q      <= occ_d;
            push_ack_q <= push_ok;
            pop_ack_q  <= pop_ok;
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + AW'(1);
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + AW'(1);
            end
        end
    end

    assign wr_en    = push_ok;
    assign rd_en    = pop_ok;
    assign wr_ptr   = wr_ptr_q;
    assign rd_ptr   = rd_ptr_q;
    assign occ      = occ_q;
    assign state    = state_q;
    assign move     = move_d;
    assign push_ack = push_ack_q;
    assign pop_ack  = pop_ack_q;

endmodule

// File: rtl/dualsrc_fifo.sv
module dualsrc_fifo
    import dsf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          src_sel,
    input  logic [DW-1:0] wdata_a,
    input  logic [DW-1:0] wdata_b,
    output logic          push_ack,
    output logic          pop_ack,
    output logic [DW-1:0] rdata
);

    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic [DW-1:0] push_word;
    occ_state_t    state;
    occ_move_t     move;

    dsf_wsel #(.DW(DW)) u_wsel (
        .sel   (src_sel),
        .src_a (wdata_a),
        .src_b (wdata_b),
        .word  (push_word)
    );

    dsf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ),
        .state    (state),
        .move     (move),
        .push_ack (push_ack),
        .pop_ack  (pop_ack)
    );

    dsf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_word (push_word),
        .rd_en   (rd_en),
        .rd_ptr  (rd_ptr),
        .rd_word (rdata)
    );

endmodule

// File: rtl/dsf_chk.sv
module dsf_chk
    import dsf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic          push_ack,
    input logic          pop_ack,
    input logic [DW-1:0] rdata,
    input logic [CW-1:0] occ,
    input occ_state_t    state
);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R4
    pop_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ack |-> $past(pop_req));

    // R5
    push_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ack |-> $past(push_req));

    // R4
    empty_pop_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && state == ST_EMPTY) |=> !pop_ack);

    // R5
    full_push_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && state == ST_FULL) |=> !push_ack);

    // R8
    full_both_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && state == ST_FULL) |=> (push_ack && pop_ack && state == ST_FULL));

    // R11
    refused_pop_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> $stable(rdata));

    // R6
    occ_follows_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ == $past(occ) + CW'(push_ack) - CW'(pop_ack));

endmodule

bind dualsrc_fifo dsf_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .push_ack (push_ack),
    .pop_ack  (pop_ack),
    .rdata    (rdata),
    .occ      (occ),
    .state    (state)
);

// File: tb/sim_dualsrc_fifo.sv
`timescale 1ns/1ps
module sim_dualsrc_fifo;

    localparam int DW    = 32;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic          src_sel = 1'b0;
    logic [DW-1:0] wdata_a = '0;
    logic [DW-1:0] wdata_b = '0;
    logic          push_ack, pop_ack;
    logic [DW-1:0] rdata;

    int            n_chk = 0;
    int            n_bad = 0;
    logic [DW-1:0] mq[$];
    logic [DW-1:0] exp_rd = '0;
    int            seq = 0;

    always #10 clk = ~clk;

    dualsrc_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .src_sel  (src_sel),
        .wdata_a  (wdata_a),
        .wdata_b  (wdata_b),
        .push_ack (push_ack),
        .pop_ack  (pop_ack),
        .rdata    (rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus; checks the registered results one edge later
    task automatic step(input string tag, input logic push, input logic pop,
                        input logic sel);
        logic          e_pop, e_push;
        logic [DW-1:0] wa, wb;
        seq++;
        wa = 32'hA000_0000 | DW'(seq);
        wb = 32'hB000_0000 | DW'(seq);
        e_pop  = pop && (mq.size() > 0);
        e_push = push && ((mq.size() < DEPTH) || e_pop);
        push_req = push;
        pop_req  = pop;
        src_sel  = sel;
        wdata_a  = wa;
        wdata_b  = wb;
        if (e_pop) exp_rd = mq.pop_front();
        if (e_push) mq.push_back(sel ? wb : wa);
        @(posedge clk);
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        check(tag, "push_ack", DW'(push_ack), DW'(e_push));
        check(tag, "pop_ack",  DW'(pop_ack),  DW'(e_pop));
        check(tag, "rdata",    rdata,         exp_rd);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "push_ack in reset", DW'(push_ack), '0);
        check("R1", "pop_ack in reset",  DW'(pop_ack),  '0);
        check("R1", "rdata in reset",    rdata,         '0);
        rst_n = 1'b1;
        mq.delete();
        exp_rd = '0;
        @(negedge clk);
        check("R1", "push_ack after reset", DW'(push_ack), '0);
        check("R1", "pop_ack after reset",  DW'(pop_ack),  '0);
    endtask

    task automatic t_reset();
        do_reset();
        step("R1", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_sel_a();
        step("R2", 1'b1, 1'b0, 1'b0);
        step("R2", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_sel_b();
        step("R3", 1'b1, 1'b0, 1'b1);
        step("R3_R6", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_empty_pop();
        step("R4", 1'b0, 1'b1, 1'b0);
        step("R11", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_fill_full();
        for (int i = 0; i < DEPTH; i++) step("R5", 1'b1, 1'b0, i[0]);
        step("R5", 1'b1, 1'b0, 1'b0);
        step("R11", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_full_both();
        step("R8", 1'b1, 1'b1, 1'b1);
        step("R8", 1'b1, 1'b1, 1'b0);
        step("R8", 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) step("R10", 1'b0, 1'b1, 1'b0);
        step("R4", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_partial_both();
        step("R7", 1'b1, 1'b0, 1'b0);
        step("R7", 1'b1, 1'b1, 1'b1);
        step("R7", 1'b1, 1'b1, 1'b0);
        step("R7", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_empty_both();
        step("R9", 1'b1, 1'b1, 1'b1);
        step("R9", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_wrap_order();
        for (int i = 0; i < 3 * DEPTH; i++) begin
            step("R10", 1'b1, 1'b0, (i % 3) == 1);
            step("R10", 1'b0, (i % 2) == 0, 1'b0);
        end
        while (mq.size() > 0) step("R10", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset_mid();
        step("R12", 1'b1, 1'b0, 1'b0);
        step("R12", 1'b1, 1'b0, 1'b1);
        do_reset();
        step("R12", 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sel_a();
        t_sel_b();
        t_empty_pop();
        t_fill_full();
        t_full_both();
        t_partial_both();
        t_empty_both();
        t_wrap_order();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule